// File: doc/BRIEF.md
# Parallel NOR Flash Command State Machine

This block models the command logic of a byte-wide parallel NOR flash. Chip enable, write enable and output enable arrive as active-low bus strobes together with a 19-bit address and an 8-bit data bus. All of them are brought into a single system clock domain through synchroniser stages. A write cycle begins when both enable and write strobes are low. It ends as soon as either strobe rises. The address is taken when the cycle begins and the data when it ends.

Multi-write command sequences are decoded into start requests for an embedded operation sequencer. These requests cover byte program, whole-array erase, single-sector erase, erase suspend and erase resume. The sequencer runs each operation for a fixed number of clock cycles against a small behavioural cell array. While an operation runs, reads return a status byte instead of array data. In that byte, bit 7 is a completion-polling bit and bit 6 flips after every read cycle.

Commands are filtered by the sequencer's activity. A running program or whole-array erase locks out every write. A running sector erase accepts only the suspend command. Once the erase is suspended, the part is back in read mode and other sectors can be read or programmed until a resume write continues the erase.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset, `bus_doe` is low and every array byte reads back as FFh.
- R2: While chip enable and output enable are low and write enable is high, `bus_doe` is high and `bus_dout` carries the byte addressed by the sector index (address bits 18:16) and line index (address bits 2:0), within four clock cycles. Each sector models 8 bytes, and the address bits between are not decoded.
- R3: The write sequence AAh at 555h, 55h at 2AAh, A0h at 555h, then a data write at the target address programs that byte to the bitwise AND of its old value and the data. Only the low 11 address bits are compared for the 555h and 2AAh keys.
- R4: A write cycle uses the address present when the later of the enable and write strobes falls, and the data present when the first of them rises.
- R5: While a program runs, a read returns a status byte. In it, bit 7 is the complement of bit 7 of the programmed data, bit 6 changes between consecutive reads, and bits 5:0 are zero. Every write during the program is ignored, F0h included.
- R6: The sequence AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, 10h at 555h sets every byte to FFh. While it runs, status reads show bit 7 as 0 and bit 6 changing between reads.
- R7: The same first five writes followed by 30h at any address in a sector erase only that sector (selected by address bits 18:16) to FFh. All other sectors keep their contents.
- R8: While a sector erase runs (not suspended), any write other than B0h is ignored. A program sequence or F0h issued in this window neither aborts the erase nor changes the array.
- R9: B0h during a sector erase suspends it. While it is suspended, reads return array data and the erase makes no progress. A program into another sector completes, and a program into the suspended sector is ignored. A later write of 30h resumes and finishes the erase.
- R10: A write of F0h, or a write whose data or key address does not match the expected next step of a sequence, returns the decoder to read mode. No command is issued for that write.
- R11: After an embedded operation completes, reads return array data and a new command sequence is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable strobe, active low |
| bus_we_n | input | 1 | Write enable strobe, active low |
| bus_oe_n | input | 1 | Output enable strobe, active low |
| bus_addr | input | 19 | Byte address |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data or status byte |
| bus_doe | output | 1 | High while read data is driven |

## Verification
The hardest state to reach from the pins is a suspended sector erase that has a program running into a different sector. This state requires three things: a long erase window, a suspend write landing inside that window, and a complete four-write program sequence decoded while the decoder sees the suspended mode. The bench sets the erase length far longer than a command sequence, issues the suspend right after the sector erase command, and then waits out a full erase period while suspended. It then reads the suspended sector to show that nothing was erased before the resume.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_LOCK  = 2'd1,
      MODE_ERASE = 2'd2,
      MODE_SUSP  = 2'd3
   } nor_mode_e;

   typedef enum logic [2:0] {
      SQ_READ = 3'd0,
      SQ_UNL1 = 3'd1,
      SQ_UNL2 = 3'd2,
      SQ_PSET = 3'd3,
      SQ_ER1  = 3'd4,
      SQ_ER2  = 3'd5,
      SQ_ER3  = 3'd6
   } nor_seq_e;

   localparam logic [7:0] CODE_KEY_A  = 8'hAA;
   localparam logic [7:0] CODE_KEY_B  = 8'h55;
   localparam logic [7:0] CODE_PROG   = 8'hA0;
   localparam logic [7:0] CODE_ERPRE  = 8'h80;
   localparam logic [7:0] CODE_CHIP   = 8'h10;
   localparam logic [7:0] CODE_SECT   = 8'h30;
   localparam logic [7:0] CODE_SUSP   = 8'hB0;
   localparam logic [7:0] CODE_RESUME = 8'h30;
   localparam logic [7:0] CODE_ABORT  = 8'hF0;

endpackage

// File: rtl/nor_bus_sync.sv
module nor_bus_sync #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_end,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_act,
   output logic              rd_end,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int VEC_W = 3 + ADDR_W + DATA_W;
   localparam logic [VEC_W-1:0] IDLE_V = {3'b111, {(VEC_W-3){1'b0}}};

   if (STAGES < 1) begin : g_bad_stages
      $error("nor_bus_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][VEC_W-1:0] pipe;
   logic [VEC_W-1:0]             s_vec;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= IDLE_V;
         else        pipe <= {ce_n, we_n, oe_n, addr, din};
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {STAGES{IDLE_V}};
         else        pipe <= {pipe[STAGES-2:0], {ce_n, we_n, oe_n, addr, din}};
      end
   end

   assign s_vec = pipe[STAGES-1];

   logic ce_s, we_s, oe_s, wr_act, wr_q, rd_q, wr_start;
   logic [ADDR_W-1:0] a_s;
   logic [DATA_W-1:0] d_s;

   assign ce_s = s_vec[VEC_W-1];
   assign we_s = s_vec[VEC_W-2];
   assign oe_s = s_vec[VEC_W-3];
   assign a_s  = s_vec[DATA_W +: ADDR_W];
   assign d_s  = s_vec[DATA_W-1:0];

   // later falling edge = both low; earlier rising edge = either high
   assign wr_act   = ~ce_s & ~we_s;
   assign rd_act   = ~ce_s & ~oe_s & we_s;
   assign wr_start = wr_act & ~wr_q;
   assign wr_end   = wr_q & ~wr_act;
   assign rd_end   = rd_q & ~rd_act;
   assign rd_addr  = a_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
         if (wr_start) wr_addr <= a_s;
         if (wr_act)   wr_data <= d_s;
      end
   end

   // R4: address stays frozen for the rest of the write cycle
   p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act && wr_q) |=> $stable(wr_addr));

endmodule

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int KEY_W  = 11,
   parameter logic [KEY_W-1:0] KEY_A = 11'h555,
   parameter logic [KEY_W-1:0] KEY_B = 11'h2AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_end,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  nor_mode_e         mode,
   output logic              go_prog,
   output logic              go_chip,
   output logic              go_sect,
   output logic              go_susp,
   output logic              go_resume
);
   if (KEY_W > ADDR_W) begin : g_bad_key
      $error("nor_cmd_decode: KEY_W exceeds ADDR_W");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("nor_cmd_decode: command codes need DATA_W of 8");
   end

   nor_seq_e st, st_nx;
   logic     at_a, at_b;

   assign at_a = (wr_addr[KEY_W-1:0] == KEY_A);
   assign at_b = (wr_addr[KEY_W-1:0] == KEY_B);

   always_comb begin
      st_nx     = st;
      go_prog   = 1'b0;
      go_chip   = 1'b0;
      go_sect   = 1'b0;
      go_susp   = 1'b0;
      go_resume = 1'b0;
      if (wr_end) begin
         unique case (mode)
            MODE_LOCK: st_nx = st;
            MODE_ERASE: begin
               st_nx   = SQ_READ;
               go_susp = (wr_data == CODE_SUSP);
            end
            default: begin
               st_nx = SQ_READ;
               if (st == SQ_PSET) begin
                  go_prog = 1'b1;
               end else if (wr_data != CODE_ABORT) begin
                  unique case (st)
                     SQ_READ: begin
                        if (wr_data == CODE_KEY_A && at_a) st_nx = SQ_UNL1;
                        else if (mode == MODE_SUSP && wr_data == CODE_RESUME) go_resume = 1'b1;
                     end
                     SQ_UNL1: if (wr_data == CODE_KEY_B && at_b) st_nx = SQ_UNL2;
                     SQ_UNL2: begin
                        if (wr_data == CODE_PROG && at_a) st_nx = SQ_PSET;
                        else if (wr_data == CODE_ERPRE && at_a && mode == MODE_IDLE) st_nx = SQ_ER1;
                     end
                     SQ_ER1: if (wr_data == CODE_KEY_A && at_a) st_nx = SQ_ER2;
                     SQ_ER2: if (wr_data == CODE_KEY_B && at_b) st_nx = SQ_ER3;
                     SQ_ER3: begin
                        if (wr_data == CODE_CHIP && at_a) go_chip = 1'b1;
                        else if (wr_data == CODE_SECT)    go_sect = 1'b1;
                     end
                     default: st_nx = SQ_READ;
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SQ_READ;
      else        st <= st_nx;
   end

   // R10: a single write never launches two commands
   p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({go_prog, go_chip, go_sect, go_susp, go_resume}));
   // R5: locked sequencer sees no command at all
   p_lock_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LOCK) |-> !(go_prog || go_chip || go_sect || go_susp || go_resume));
   // R8: running sector erase only lets a suspend through
   p_erase_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ERASE) |-> !(go_prog || go_chip || go_sect || go_resume));

endmodule

// File: rtl/nor_op_seq.sv
module nor_op_seq
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 3,
   parameter int PROG_CYC  = 16,
   parameter int ERASE_CYC = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go_prog,
   input  logic                 go_chip,
   input  logic                 go_sect,
   input  logic                 go_susp,
   input  logic                 go_resume,
   input  logic [ADDR_W-1:0]    go_addr,
   input  logic [DATA_W-1:0]    go_data,
   output nor_mode_e            mode,
   output logic                 poll_bit,
   output logic                 pg_fire,
   output logic [ADDR_W-1:0]    pg_addr,
   output logic [DATA_W-1:0]    pg_data,
   output logic                 er_all,
   output logic                 er_one,
   output logic [SECT_BITS-1:0] er_sect
);
   localparam int PW = $clog2(PROG_CYC + 1);
   localparam int EW = $clog2(ERASE_CYC + 1);

   if (PROG_CYC < 2 || ERASE_CYC < 2) begin : g_bad_len
      $error("nor_op_seq: operation lengths must be at least 2");
   end
   if (SECT_BITS < 1 || SECT_BITS > ADDR_W) begin : g_bad_sect
      $error("nor_op_seq: SECT_BITS out of range");
   end

   logic          prog_run, erase_run, susp, chip;
   logic [PW-1:0] pg_cnt;
   logic [EW-1:0] er_cnt;
   logic          er_fire, prog_ok;

   assign pg_fire = prog_run && (pg_cnt == PW'(PROG_CYC - 1));
   assign er_fire = erase_run && !susp && (er_cnt == EW'(ERASE_CYC - 1));
   assign er_all  = er_fire && chip;
   assign er_one  = er_fire && !chip;
   assign prog_ok = go_prog && !(susp && go_addr[ADDR_W-1 -: SECT_BITS] == er_sect);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_run  <= 1'b0;
         erase_run <= 1'b0;
         susp      <= 1'b0;
         chip      <= 1'b0;
         pg_cnt    <= '0;
         er_cnt    <= '0;
         pg_addr   <= '0;
         pg_data   <= '0;
         er_sect   <= '0;
      end else begin
         if (prog_ok) begin
            prog_run <= 1'b1;
            pg_cnt   <= '0;
            pg_addr  <= go_addr;
            pg_data  <= go_data;
         end else if (pg_fire) begin
            prog_run <= 1'b0;
         end else if (prog_run) begin
            pg_cnt <= pg_cnt + 1'b1;
         end

         if (go_chip || go_sect) begin
            erase_run <= 1'b1;
            chip      <= go_chip;
            er_cnt    <= '0;
            if (go_sect) er_sect <= go_addr[ADDR_W-1 -: SECT_BITS];
         end else if (er_fire) begin
            erase_run <= 1'b0;
         end else if (erase_run && !susp) begin
            er_cnt <= er_cnt + 1'b1;
         end

         if (go_susp)        susp <= 1'b1;
         else if (go_resume) susp <= 1'b0;
      end
   end

   always_comb begin
      if (prog_run || (erase_run && chip)) mode = MODE_LOCK;
      else if (erase_run && !susp)         mode = MODE_ERASE;
      else if (erase_run)                  mode = MODE_SUSP;
      else                                 mode = MODE_IDLE;
   end

   assign poll_bit = prog_run ? ~pg_data[DATA_W-1] : 1'b0;

   // R9: suspension only exists inside an erase
   p_susp_in_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      susp |-> erase_run);
   // R9: a suspended erase does not advance
   p_susp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_run && susp && !go_resume) |=> $stable(er_cnt));
   // R3: a program lasts its full length before it ends
   p_prog_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_run) |-> ($past(pg_cnt) == PW'(PROG_CYC - 1)));

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 3,
   parameter int LINE_BITS = 3,
   parameter bit AND_PROG  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pg_fire,
   input  logic [SECT_BITS+LINE_BITS-1:0] pg_idx,
   input  logic [DATA_W-1:0]             pg_data,
   input  logic                          er_all,
   input  logic                          er_one,
   input  logic [SECT_BITS-1:0]          er_sect,
   input  logic [SECT_BITS+LINE_BITS-1:0] rd_idx,
   output logic [DATA_W-1:0]             rd_data
);
   localparam int IW    = SECT_BITS + LINE_BITS;
   localparam int DEPTH = 1 << IW;
   localparam int LINES = 1 << LINE_BITS;

   if (IW > 10) begin : g_bad_depth
      $error("nor_cell_array: behavioural array too large");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] prog_val;

   if (AND_PROG) begin : g_and
      assign prog_val = mem[pg_idx] & pg_data;
   end else begin : g_over
      assign prog_val = pg_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (er_all) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (er_one) begin
         for (int l = 0; l < LINES; l++) mem[{er_sect, LINE_BITS'(l)}] <= '1;
      end else if (pg_fire) begin
         mem[pg_idx] <= prog_val;
      end
   end

   assign rd_data = mem[rd_idx];

   // R9: program and erase never write the array together
   p_no_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pg_fire && (er_all || er_one)));

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 8,
   parameter int SECT_BITS   = 3,
   parameter int LINE_BITS   = 3,
   parameter int KEY_W       = 11,
   parameter int SYNC_STAGES = 2,
   parameter int PROG_CYC    = 16,
   parameter int ERASE_CYC   = 64,
   parameter bit AND_PROG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ce_n,
   input  logic              bus_we_n,
   input  logic              bus_oe_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe
);
   localparam int IW = SECT_BITS + LINE_BITS;

   if (SECT_BITS + LINE_BITS > ADDR_W) begin : g_bad_map
      $error("nor_cmd_ctrl: sector and line bits exceed address width");
   end

   logic              wr_end, rd_act, rd_end;
   logic [ADDR_W-1:0] wr_addr, rd_addr, pg_addr;
   logic [DATA_W-1:0] wr_data, pg_data, rd_data;
   logic              go_prog, go_chip, go_sect, go_susp, go_resume;
   nor_mode_e         mode;
   logic              poll_bit, pg_fire, er_all, er_one;
   logic [SECT_BITS-1:0] er_sect;
   logic [IW-1:0]     pg_idx, rd_idx;
   logic              status_on, tog;

   nor_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
      .addr(bus_addr), .din(bus_din), .wr_end(wr_end), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_act(rd_act), .rd_end(rd_end), .rd_addr(rd_addr));

   nor_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data),
      .mode(mode), .go_prog(go_prog), .go_chip(go_chip), .go_sect(go_sect),
      .go_susp(go_susp), .go_resume(go_resume));

   nor_op_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
                .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_chip(go_chip), .go_sect(go_sect),
      .go_susp(go_susp), .go_resume(go_resume), .go_addr(wr_addr), .go_data(wr_data),
      .mode(mode), .poll_bit(poll_bit), .pg_fire(pg_fire), .pg_addr(pg_addr),
      .pg_data(pg_data), .er_all(er_all), .er_one(er_one), .er_sect(er_sect));

   assign pg_idx = {pg_addr[ADDR_W-1 -: SECT_BITS], pg_addr[LINE_BITS-1:0]};
   assign rd_idx = {rd_addr[ADDR_W-1 -: SECT_BITS], rd_addr[LINE_BITS-1:0]};

   nor_cell_array #(.DATA_W(DATA_W), .SECT_BITS(SECT_BITS), .LINE_BITS(LINE_BITS),
                    .AND_PROG(AND_PROG)) u_arr (
      .clk(clk), .rst_n(rst_n), .pg_fire(pg_fire), .pg_idx(pg_idx), .pg_data(pg_data),
      .er_all(er_all), .er_one(er_one), .er_sect(er_sect), .rd_idx(rd_idx),
      .rd_data(rd_data));

   assign status_on = (mode == MODE_LOCK) || (mode == MODE_ERASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog      <= 1'b0;
         bus_doe  <= 1'b0;
         bus_dout <= '0;
      end else begin
         if (rd_end && status_on) tog <= ~tog;
         bus_doe  <= rd_act;
         bus_dout <= status_on ? {poll_bit, tog, {(DATA_W-2){1'b0}}} : rd_data;
      end
   end

   // R2: output enable follows the synchronised read window
   p_doe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_act |=> !bus_doe);

endmodule

// File: tb/nor_cmd_ctrl_tb_top.sv
module nor_cmd_ctrl_tb_top;
   localparam int PCYC = 150;
   localparam int ECYC = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [18:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        doe;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   nor_cmd_ctrl #(.PROG_CYC(PCYC), .ERASE_CYC(ECYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
      .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr_skew(input logic [18:0] a1, input logic [18:0] a2,
                              input logic [7:0] d1, input logic [7:0] d2);
      @(negedge clk);
      addr = a1; din = d1; ce_n = 1'b0;
      idle(2); we_n = 1'b0;
      idle(2); addr = a2; din = d2;
      idle(2); we_n = 1'b1;
      idle(4); ce_n = 1'b1;
      idle(2);
   endtask

   task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
      bus_wr_skew(a, a, d, d);
   endtask

   task automatic bus_rd(input logic [18:0] a, output logic [7:0] v, output logic oe_seen);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      idle(6);
      v = dout; oe_seen = doe;
      oe_n = 1'b1; ce_n = 1'b1;
      idle(4);
   endtask

   task automatic rd_chk(input string req, input logic [18:0] a, input logic [7:0] exp);
      logic [7:0] v; logic o;
      bus_rd(a, v, o);
      check(req, v, exp);
   endtask

   task automatic unlock();
      bus_wr(19'h555, 8'hAA);
      bus_wr(19'h2AA, 8'h55);
   endtask

   task automatic prog_cmd(input logic [18:0] a, input logic [7:0] d);
      unlock();
      bus_wr(19'h555, 8'hA0);
      bus_wr(a, d);
   endtask

   task automatic erase_pre();
      unlock();
      bus_wr(19'h555, 8'h80);
      unlock();
   endtask

   // two reads during an operation: bit7 as given, bit6 differs, low bits zero
   task automatic status_pair(input string req, input logic exp7);
      logic [7:0] v1, v2; logic o;
      bus_rd(19'h0, v1, o);
      bus_rd(19'h0, v2, o);
      check({req, " poll bit"}, {7'd0, v1[7]}, {7'd0, exp7});
      check({req, " low bits"}, {2'b00, v1[5:0]}, 8'h00);
      check({req, " toggle"}, {7'd0, v1[6] ^ v2[6]}, 8'h01);
   endtask

   task automatic t_reset();
      logic [7:0] v; logic o;
      check("R1 doe idle", {7'd0, doe}, 8'h00);
      bus_rd(19'h12345, v, o);
      check("R1 erased byte", v, 8'hFF);
      check("R2 doe during read", {7'd0, o}, 8'h01);
      idle(2);
      check("R2 doe after read", {7'd0, doe}, 8'h00);
   endtask

   task automatic t_program();
      prog_cmd(19'h10003, 8'h5A);
      status_pair("R5 program status", 1'b1);
      bus_wr(19'h555, 8'hF0);
      prog_cmd(19'h30004, 8'h00);
      idle(200);
      rd_chk("R3 programmed byte", 19'h10003, 8'h5A);
      rd_chk("R5 lockout", 19'h30004, 8'hFF);
      prog_cmd(19'h10003, 8'h0F);
      idle(200);
      rd_chk("R3 AND program / R11 reaccept", 19'h10003, 8'h0A);
   endtask

   task automatic t_edges();
      unlock();
      bus_wr(19'h555, 8'hA0);
      bus_wr_skew(19'h20001, 19'h20002, 8'hC3, 8'h33);
      idle(200);
      rd_chk("R4 address at start", 19'h20001, 8'h33);
      rd_chk("R4 moved address untouched", 19'h20002, 8'hFF);
   endtask

   task automatic t_abort();
      unlock();
      bus_wr(19'h555, 8'hF0);
      bus_wr(19'h555, 8'hA0);
      bus_wr(19'h30000, 8'h00);
      idle(200);
      rd_chk("R10 abort code", 19'h30000, 8'hFF);
      bus_wr(19'h555, 8'hAA);
      bus_wr(19'h2AB, 8'h55);
      bus_wr(19'h555, 8'hA0);
      bus_wr(19'h30001, 8'h00);
      idle(200);
      rd_chk("R10 wrong key address", 19'h30001, 8'hFF);
      prog_cmd(19'h30002, 8'h81);
      idle(200);
      rd_chk("R11 sequence after abort", 19'h30002, 8'h81);
   endtask

   task automatic t_sector();
      prog_cmd(19'h40005, 8'h11);
      idle(200);
      prog_cmd(19'h50005, 8'h22);
      idle(200);
      erase_pre();
      bus_wr(19'h40000, 8'h30);
      status_pair("R6 erase status", 1'b0);
      bus_wr(19'h555, 8'hF0);
      prog_cmd(19'h50006, 8'h00);
      idle(700);
      rd_chk("R7 sector erased", 19'h40005, 8'hFF);
      rd_chk("R7 other sector kept", 19'h50005, 8'h22);
      rd_chk("R7 earlier sector kept", 19'h10003, 8'h0A);
      rd_chk("R8 program ignored", 19'h50006, 8'hFF);
   endtask

   task automatic t_suspend();
      prog_cmd(19'h60002, 8'h44);
      idle(200);
      erase_pre();
      bus_wr(19'h60000, 8'h30);
      bus_wr(19'h00000, 8'hB0);
      rd_chk("R9 read in suspend", 19'h60002, 8'h44);
      prog_cmd(19'h70001, 8'h77);
      idle(200);
      rd_chk("R9 program other sector", 19'h70001, 8'h77);
      prog_cmd(19'h60003, 8'h00);
      idle(700);
      rd_chk("R9 program suspended sector ignored", 19'h60003, 8'hFF);
      rd_chk("R9 erase frozen", 19'h60002, 8'h44);
      bus_wr(19'h12345, 8'h30);
      idle(700);
      rd_chk("R9 resumed erase done", 19'h60002, 8'hFF);
      rd_chk("R9 other sector after resume", 19'h70001, 8'h77);
   endtask

   task automatic t_chip();
      erase_pre();
      bus_wr(19'h555, 8'h10);
      status_pair("R6 chip erase status", 1'b0);
      idle(700);
      rd_chk("R6 chip erased a", 19'h10003, 8'hFF);
      rd_chk("R6 chip erased b", 19'h70001, 8'hFF);
      rd_chk("R6 chip erased c", 19'h20001, 8'hFF);
      prog_cmd(19'h00007, 8'h3C);
      idle(200);
      rd_chk("R11 program after chip erase", 19'h00007, 8'h3C);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_program();
      t_edges();
      t_abort();
      t_sector();
      t_suspend();
      t_chip();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got hung expected finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule